// File: doc/BRIEF.md
# Periodic Tick Timer

A down-counting tick timer for periodic interrupts. A reload register sets the period. The counter runs only while the enable bit is set. Each time it falls to zero it reloads and starts again, so it ticks once every reload+1 cycles. Each arrival at zero sets a sticky wrap flag. If the interrupt enable is set, the arrival at zero also raises a one-cycle interrupt request.

Software reaches the timer through a small word-addressed register port with three registers:

| Index | Register |
|-------|----------|
| 0 | control/status |
| 1 | reload |
| 2 | current count |

`rdata_o` always shows the register selected by `addr_i`. The read strobe `rd_en_i` only marks the access as a read that has side effects. The side effect is the clearing of the wrap flag. A read marked as coming from a debugger leaves the flag alone when the debugger's master-type qualifier is 1.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status word reads 0x00000004, the reload and current registers read 0, and `irq_o` is low.
- R2: Control bit 0 enables counting. When it is 0 the counter holds its value. When it is 1, a count of 0 loads the reload value on the next clock, and any other count decrements by one per clock, so the count repeats every reload+1 cycles.
- R3: Control bit 16 (the wrap flag) becomes 1 on the clock where the count moves from 1 to 0.
- R4: A software read of the control/status word (index 0, `rd_en_i`=1, `dbg_i`=0) returns the flag and clears it on that clock. If a wrap lands on the same clock, the flag stays set.
- R5: A debugger read (`dbg_i`=1) clears the flag only when `dbg_mtype_i`=0. When `dbg_mtype_i`=1 the flag is unchanged.
- R6: Control bit 2 (clock source) always reads 1, and writes to it have no effect.
- R7: `irq_o` is a one-cycle pulse. It rises on the same clock where the count moves from 1 to 0, and only when control bit 1 (interrupt enable) is 1. When bit 1 is 0, only the flag records the event.
- R8: Control bits 3 to 15 and 17 to 31 read as 0 whatever value is written.
- R9: Any write to the current register (index 2) sets the count to 0 and clears the flag, with no flag set and no `irq_o` pulse, even on a clock where the count would have gone from 1 to 0.
- R10: When the counter is enabled with a count of 0, its first step loads the reload value without setting the flag. A reload value of 0 leaves the counter at 0 after it finishes its current run down, with no further flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register index (0 control/status, 1 reload, 2 current) |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (qualifies side effects) |
| wdata_i | input | 32 | Write data |
| dbg_i | input | 1 | Access is made by a debugger |
| dbg_mtype_i | input | 1 | Debugger master-type qualifier |
| rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench sweeps reload values 1 to 6 with the interrupt enable both off and on. It predicts every count value and interrupt pulse from the period formula, so a reload that is off by one cycle, or a wrap that fires on the reload step, shows up as a shifted count. It checks the clear-on-read rule for software reads and for both debugger qualifiers. A design that inverted the qualifier would lose, or keep, the flag on the wrong read. A write to the current register lands on the exact clock of a 1-to-0 step, so a design that let the count take priority there would pulse `irq_o` or set the flag. Finally, writing zero to the reload while the counter runs must let the counter finish its run and then park at 0. A design that kept reloading would go on setting the flag.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL    = 2'd0,
    A_RELOAD  = 2'd1,
    A_CURRENT = 2'd2
  } tick_addr_e;

  // bit positions software decodes
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_IRQ  = 1;
  localparam int unsigned B_CLK  = 2;
  localparam int unsigned B_FLAG = 16;
endpackage

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_reload_i,
  input  logic              wr_cur_i,
  input  logic              rd_clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic              tick_en_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flag_o
);
  logic             en_q, tick_q, flag_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      tick_q <= 1'b0;
    end else if (wr_ctrl_i) begin
      en_q   <= wdata_i[B_EN];
      tick_q <= wdata_i[B_IRQ];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          reload_q <= '0;
    else if (wr_reload_i) reload_q <= wdata_i[CNT_W-1:0];
  end

  // current-write clear beats wrap; wrap beats read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (wr_cur_i) flag_q <= 1'b0;
    else if (wrap_i)   flag_q <= 1'b1;
    else if (rd_clr_i) flag_q <= 1'b0;
  end

  assign en_o      = en_q;
  assign tick_en_o = tick_q;
  assign reload_o  = reload_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign wrap_o  = en_i && !clr_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i) begin
      if (at_zero)    cnt_q <= reload_i;
      else            cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap_o && tick_en_i;
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tick_read_mux.sv
module tick_read_mux
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic [REG_AW-1:0] addr_i,
  input  logic              en_i,
  input  logic              tick_en_i,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_EN]   = en_i;
        rdata_o[B_IRQ]  = tick_en_i;
        rdata_o[B_CLK]  = 1'b1;
        rdata_o[B_FLAG] = flag_i;
      end
      A_RELOAD:  rdata_o = {{PAD_W{1'b0}}, reload_i};
      A_CURRENT: rdata_o = {{PAD_W{1'b0}}, cnt_i};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              dbg_i,
  input  logic              dbg_mtype_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic             wr_ctrl, wr_reload, wr_cur, rd_clr;
  logic             en, tick_en, flag, wrap;
  logic [CNT_W-1:0] reload, cnt;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_reload = wr_en_i && (addr_i == A_RELOAD);
  assign wr_cur    = wr_en_i && (addr_i == A_CURRENT);
  // debugger with master-type 1 reads without side effect
  assign rd_clr    = rd_en_i && (addr_i == A_CTRL) && !(dbg_i && dbg_mtype_i);

  tick_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr_ctrl),
    .wr_reload_i (wr_reload),
    .wr_cur_i    (wr_cur),
    .rd_clr_i    (rd_clr),
    .wdata_i     (wdata_i),
    .wrap_i      (wrap),
    .en_o        (en),
    .tick_en_o   (tick_en),
    .reload_o    (reload),
    .flag_o      (flag)
  );

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .tick_en_i (tick_en),
    .clr_i     (wr_cur),
    .reload_i  (reload),
    .cnt_o     (cnt),
    .wrap_o    (wrap),
    .irq_o     (irq_o)
  );

  tick_read_mux #(.CNT_W(CNT_W)) u_rmux (
    .addr_i    (addr_i),
    .en_i      (en),
    .tick_en_i (tick_en),
    .flag_i    (flag),
    .reload_i  (reload),
    .cnt_i     (cnt),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       addr_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic             dbg_i,
  input logic             dbg_mtype_i,
  input logic [31:0]      rdata_o,
  input logic             irq_o,
  input logic             en,
  input logic             flag,
  input logic [CNT_W-1:0] cnt
);
  logic cur_wr;
  assign cur_wr = wr_en_i && (addr_i == 2'd2);

  // R2
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cur_wr) |=> $stable(cnt));

  // R3
  wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cur_wr && cnt == CNT_W'(1)) |=> flag);

  // R4
  read_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == 2'd0 && !dbg_i && !(en && cnt == CNT_W'(1))) |=> !flag);

  // R5
  dbg_keeps_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == 2'd0 && dbg_i && dbg_mtype_i && flag) |=> flag);

  // R6
  clk_src_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> rdata_o[2]);

  // R8
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[15:3] == '0 && rdata_o[31:17] == '0));

  // R7
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R7
  irq_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cnt == '0 && flag));

  // R9
  cur_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_wr |=> (cnt == '0 && !flag && !irq_o));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .dbg_i       (dbg_i),
  .dbg_mtype_i (dbg_mtype_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .en          (en),
  .flag        (flag),
  .cnt         (cnt)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        dbg_i = 1'b0;
  logic        dbg_mtype_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] rd_val;

  localparam logic [1:0] CTL = 2'd0, RLD = 2'd1, CUR = 2'd2;
  localparam logic [31:0] CLK_BIT = 32'h4, FLAG_BIT = 32'h1_0000;

  always #5 clk_i = ~clk_i;

  tick_timer i_tick_timer (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .dbg_i, .dbg_mtype_i, .rdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // tasks start and end at a negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic dbg, input logic mt, output logic [31:0] v);
    addr_i = a; rd_en_i = 1'b1; dbg_i = dbg; dbg_mtype_i = mt;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0; dbg_i = 1'b0; dbg_mtype_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(CTL, 0, 0, rd_val); chk("R1 ctrl", rd_val, 32'h4);
    rd(RLD, 0, 0, rd_val); chk("R1 reload", rd_val, 32'h0);
    rd(CUR, 0, 0, rd_val); chk("R1 current", rd_val, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R6 R8: clock bit fixed, reserved bits zero
    wr(CTL, 32'hFFFE_FFF8);
    rd(CTL, 0, 0, rd_val); chk("R6 R8 ctrl write", rd_val, CLK_BIT);

    // R2 R3 R7 R10 sweep of period and interrupt enable
    for (int t = 0; t < 2; t++) begin
      for (int r = 1; r <= 6; r++) begin
        wr(CTL, 32'h0);
        wr(CUR, 32'h0);
        wr(RLD, 32'(r));
        wr(CTL, 32'h1 | 32'(t << 1));
        addr_i = CUR;
        for (int n = 1; n <= 3*r + 3; n++) begin
          int exp_c;
          @(negedge clk_i);
          exp_c = r - ((n - 1) % (r + 1));
          chk("R2 R10 count", rdata_o, 32'(exp_c));
          chk("R7 irq", {31'b0, irq_o}, (t == 1 && exp_c == 0) ? 32'h1 : 32'h0);
        end
        wr(CTL, 32'(t << 1));
        rd(CTL, 0, 0, rd_val); chk("R3 R4 flag set", rd_val, FLAG_BIT | CLK_BIT | 32'(t << 1));
        rd(CTL, 0, 0, rd_val); chk("R4 flag cleared", rd_val, CLK_BIT | 32'(t << 1));
      end
    end

    // R2 hold while disabled, resume
    wr(CUR, 32'h0);
    wr(RLD, 32'd5);
    wr(CTL, 32'h1);
    wr(CTL, 32'h0);
    idle(4);
    rd(CUR, 0, 0, rd_val); chk("R2 hold", rd_val, 32'd5);
    wr(CTL, 32'h1);
    addr_i = CUR; #1 chk("R2 resume0", rdata_o, 32'd5);
    @(negedge clk_i); chk("R2 resume1", rdata_o, 32'd4);
    wr(CTL, 32'h0);

    // R5 debugger reads
    wr(CUR, 32'h0);
    wr(RLD, 32'd1);
    wr(CTL, 32'h1);
    idle(3);
    wr(CTL, 32'h0);
    rd(CTL, 1, 1, rd_val); chk("R5 dbg mt1 value", rd_val, FLAG_BIT | CLK_BIT);
    rd(CTL, 1, 1, rd_val); chk("R5 dbg mt1 kept", rd_val, FLAG_BIT | CLK_BIT);
    rd(CTL, 1, 0, rd_val); chk("R5 dbg mt0 value", rd_val, FLAG_BIT | CLK_BIT);
    rd(CTL, 0, 0, rd_val); chk("R5 dbg mt0 cleared", rd_val, CLK_BIT);

    // R9 current write clears flag
    wr(CTL, 32'h1);
    idle(3);
    wr(CTL, 32'h0);
    wr(CUR, 32'h0);
    rd(CTL, 0, 0, rd_val); chk("R9 flag cleared", rd_val, CLK_BIT);

    // R9 current write on the 1->0 clock: no flag, no irq
    wr(RLD, 32'd4);
    wr(CTL, 32'h3);
    idle(4);
    wr(CUR, 32'h0);
    chk("R9 irq", {31'b0, irq_o}, 32'h0);
    addr_i = CUR; #1 chk("R9 count", rdata_o, 32'h0);
    rd(CTL, 0, 0, rd_val); chk("R9 no flag", rd_val, 32'h7);

    // R10 reload 0 from zero: stays parked, no flag
    wr(CTL, 32'h0);
    wr(CUR, 32'h0);
    wr(RLD, 32'h0);
    wr(CTL, 32'h3);
    idle(5);
    chk("R10 irq zero reload", {31'b0, irq_o}, 32'h0);
    rd(CUR, 0, 0, rd_val); chk("R10 parked", rd_val, 32'h0);
    rd(CTL, 0, 0, rd_val); chk("R10 no flag", rd_val, 32'h7);

    // R10 reload 0 while running: finish run then park
    wr(RLD, 32'd3);
    idle(2);
    wr(RLD, 32'h0);
    idle(6);
    rd(CTL, 0, 0, rd_val); chk("R10 final wrap flag", rd_val, FLAG_BIT | 32'h7);
    idle(6);
    rd(CUR, 0, 0, rd_val); chk("R10 stopped", rd_val, 32'h0);
    rd(CTL, 0, 0, rd_val); chk("R10 no more flag", rd_val, 32'h7);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule